// File: doc/BRIEF.md
# Epoch-Aligned Start Handshake

This block lines up the program start of two devices that share a periodic epoch pulse. The devices are joined by a one-way vector link. The epoch pulse comes from counters that are already aligned outside the block. A single parameter picks the role of each instance: initiator or follower.

The initiator is armed by a go request and captures the vector to be sent. It then holds until the next epoch pulse. In the cycle after that pulse it places the vector on the link and raises its own start strobe.

The follower listens on the link and stores the first vector that arrives. It then waits for the following epoch pulse and raises its start strobe one cycle after that pulse, presenting the stored vector. The two sides therefore begin on epoch boundaries exactly one epoch apart.

Top module: `epoch_start_sync`

## Requirements
- R1: While reset is applied and right after it, start_o, run_o, tx_valid_o and overrun_o are all low.
- R2: An initiator that has not seen go_i high sends nothing on the link and does not start, however many epoch pulses pass.
- R3: After go_i, the initiator captures vec_i in that cycle and ignores later changes of vec_i. It holds until an epoch pulse. In the cycle after that pulse, tx_valid_o and start_o are high together, with the captured vector on tx_data_o and start_vec_o.
- R4: Each instance raises start_o for exactly one cycle. run_o stays high from then on, and further go_i requests cause no second send or start.
- R5: The follower stores the first valid link vector in the cycle it arrives. It does not start before the next epoch pulse.
- R6: The follower raises start_o in the cycle after the first epoch pulse that follows capture. start_vec_o carries the stored vector.
- R7: A vector that arrives in the same cycle as an epoch pulse counts as captured in the current epoch, and the follower starts one cycle after the next pulse.
- R8: A second vector that arrives after capture and before start is dropped: start_vec_o keeps the first vector, and overrun_o goes high and stays high until reset.
- R9: Vectors that arrive after the follower has started are ignored: start_vec_o is unchanged and overrun_o stays low.
- R10: With an initiator linked directly to a follower, the follower's start comes exactly one epoch period after the initiator's start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| epoch_i | input | 1 | One-cycle epoch boundary pulse from the aligned counter |
| go_i | input | 1 | Arms the initiator (unused by the follower) |
| vec_i | input | VEC_W | Start vector to send (initiator) |
| rx_valid_i | input | 1 | Link vector valid (follower) |
| rx_data_i | input | VEC_W | Link vector data (follower) |
| tx_valid_o | output | 1 | Link vector valid (initiator) |
| tx_data_o | output | VEC_W | Link vector data (initiator) |
| start_o | output | 1 | One-cycle start strobe |
| run_o | output | 1 | High once this side has started |
| start_vec_o | output | VEC_W | Vector presented with the start strobe |
| overrun_o | output | 1 | Sticky flag: an extra vector arrived before start |

## Verification
The in-module assertions check every cycle that:
- any send or start directly follows an epoch pulse;
- a start lasts a single cycle;
- run_o and overrun_o never fall;
- the presented vector is frozen once running.

Only the bench scenarios can show that the correct vector travels end to end and that the follower lags by exactly one epoch. The same holds for the same-cycle arrival case, the dropped second vector and the ignored post-start traffic. A scoreboard compares each start against the cycle and vector predicted from the epoch pulses.

// File: rtl/epoch_start_sync.sv
module epoch_start_sync #(
  parameter int VEC_W     = 32,
  parameter bit IS_PARENT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             epoch_i,
  input  logic             go_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             rx_valid_i,
  input  logic [VEC_W-1:0] rx_data_i,
  output logic             tx_valid_o,
  output logic [VEC_W-1:0] tx_data_o,
  output logic             start_o,
  output logic             run_o,
  output logic [VEC_W-1:0] start_vec_o,
  output logic             overrun_o
);

  // Initiator: IDLE -> ARMED (waiting for epoch) -> HOLD (sending) -> RUN
  // Follower : IDLE -> ARMED (polling)          -> HOLD (captured) -> RUN
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_HOLD, ST_RUN} st_t;

  st_t              st, st_nx;
  logic [VEC_W-1:0] buf_q;
  logic             start_q;
  logic             ovr_q;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (!IS_PARENT || go_i) st_nx = ST_ARMED;
      ST_ARMED: if (IS_PARENT ? epoch_i : rx_valid_i) st_nx = ST_HOLD;
      ST_HOLD:  if (IS_PARENT || epoch_i) st_nx = ST_RUN;
      default:  st_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      buf_q   <= '0;
      start_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      st      <= st_nx;
      start_q <= epoch_i && (st == (IS_PARENT ? ST_ARMED : ST_HOLD));
      if (IS_PARENT) begin
        if (st == ST_IDLE && go_i) buf_q <= vec_i;
      end else begin
        if (st == ST_ARMED && rx_valid_i) buf_q <= rx_data_i;
        if (st == ST_HOLD && rx_valid_i) ovr_q <= 1'b1;
      end
    end
  end

  assign tx_valid_o  = IS_PARENT && (st == ST_HOLD);
  assign tx_data_o   = IS_PARENT ? buf_q : '0;
  assign start_o     = start_q;
  assign run_o       = (st == ST_RUN) || (IS_PARENT && st == ST_HOLD);
  assign start_vec_o = buf_q;
  assign overrun_o   = ovr_q;

  a_r3_tx_after_epoch: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> $past(epoch_i));

  a_r6_start_after_epoch: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(epoch_i));

  a_r5_start_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(st == (IS_PARENT ? ST_ARMED : ST_HOLD)));

  a_r4_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  a_r4_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |=> run_o);

  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);

  a_r9_vec_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !start_o) |-> $stable(start_vec_o));

endmodule

// File: tb/epoch_start_sync_bench.sv
module epoch_start_sync_bench;
  localparam int W = 32;

  logic clk = 1'b0, rst_n = 1'b0, epoch = 1'b0, go = 1'b0;
  logic drv_sel = 1'b0, drv_valid = 1'b0;
  logic [W-1:0] pvec = '0, drv_data = '0;

  logic p_tx_v, p_start, p_run, p_ovr;
  logic [W-1:0] p_tx_d, p_sv;
  logic c_tx_v, c_start, c_run, c_ovr;
  logic [W-1:0] c_tx_d, c_sv;
  logic c_rx_v;
  logic [W-1:0] c_rx_d;

  assign c_rx_v = drv_sel ? drv_valid : p_tx_v;
  assign c_rx_d = drv_sel ? drv_data  : p_tx_d;

  always #4 clk = ~clk;

  epoch_start_sync #(.VEC_W(W), .IS_PARENT(1'b1)) u_epoch_start_sync (
    .clk(clk), .rst_n(rst_n), .epoch_i(epoch), .go_i(go), .vec_i(pvec),
    .rx_valid_i(1'b0), .rx_data_i('0),
    .tx_valid_o(p_tx_v), .tx_data_o(p_tx_d), .start_o(p_start), .run_o(p_run),
    .start_vec_o(p_sv), .overrun_o(p_ovr));

  epoch_start_sync #(.VEC_W(W), .IS_PARENT(1'b0)) u_epoch_start_sync_child (
    .clk(clk), .rst_n(rst_n), .epoch_i(epoch), .go_i(1'b0), .vec_i('0),
    .rx_valid_i(c_rx_v), .rx_data_i(c_rx_d),
    .tx_valid_o(c_tx_v), .tx_data_o(c_tx_d), .start_o(c_start), .run_o(c_run),
    .start_vec_o(c_sv), .overrun_o(c_ovr));

  typedef struct {bit who; int cyc; logic [W-1:0] v; string req;} exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0, ptx_count = 0;
  bit done = 1'b0;

  always_ff @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(bit who, int c, logic [W-1:0] v, string req);
    exp_t e;
    e.who = who; e.cyc = c; e.v = v; e.req = req;
    q.push_back(e);
  endtask

  task automatic mon_start(bit who, logic s, logic [W-1:0] v);
    exp_t e;
    if (s) begin
      if (q.size() == 0) chk(1'b0, "R4", who ? "unexpected follower start" : "unexpected initiator start", 1, 0);
      else begin
        e = q.pop_front();
        chk(e.who == who, e.req, "start side", who, e.who);
        chk(e.cyc == cyc, e.req, "start cycle", cyc, e.cyc);
        chk(e.v == v, e.req, "start vector", v, e.v);
      end
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (p_tx_v) ptx_count++;
    mon_start(1'b0, p_start, p_sv);
    mon_start(1'b1, c_start, c_sv);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    epoch = 1'b1;
    @(negedge clk) epoch = 1'b0;
  endtask

  task automatic send(logic [W-1:0] d);
    drv_valid = 1'b1; drv_data = d;
    @(negedge clk) drv_valid = 1'b0;
  endtask

  task automatic do_reset(bit sel);
    rst_n = 1'b0; epoch = 1'b0; go = 1'b0; drv_valid = 1'b0; drv_sel = sel;
    ptx_count = 0;
    idle(3);
    chk(!p_start && !c_start && !p_run && !c_run && !p_tx_v && !c_ovr, "R1",
        "outputs in reset", {p_start, c_start, p_run, c_run, p_tx_v, c_ovr}, 0);
    rst_n = 1'b1;
    idle(2);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    done = 1'b1;
    chk(1'b0, "R1", "watchdog expired", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int t0, t1;
    @(negedge clk);
    do_reset(1'b0);
    chk(!p_start && !c_start && !p_run && !c_run && !p_tx_v && !c_ovr, "R1",
        "outputs after reset", {p_start, c_start, p_run, c_run, p_tx_v, c_ovr}, 0);

    // R2: no go, epochs pass
    repeat (3) begin pulse(); idle(5); end
    chk(ptx_count == 0, "R2", "link sends without go", ptx_count, 0);
    chk(!p_run && !c_run, "R2", "run without go", {p_run, c_run}, 0);

    // R3: arm, vector latched at go
    pvec = 32'hA5A5_1234; go = 1'b1;
    @(negedge clk) go = 1'b0; pvec = 32'h5A5A_9999;
    idle(4);
    chk(ptx_count == 0, "R3", "send before epoch", ptx_count, 0);
    t0 = cyc + 1;
    push(1'b0, t0, 32'hA5A5_1234, "R3");
    pulse();
    idle(2);
    chk(ptx_count == 1, "R3", "link sends after epoch", ptx_count, 1);
    chk(c_sv == 32'hA5A5_1234, "R5", "follower captured vector", c_sv, 32'hA5A5_1234);
    chk(!c_run, "R5", "follower running before next epoch", c_run, 0);
    idle(5);
    t1 = cyc + 1;
    chk(t1 - t0 == 8, "R10", "epoch period in bench", t1 - t0, 8);
    push(1'b1, t1, 32'hA5A5_1234, "R10");
    pulse();
    idle(2);
    // R4: second go ignored
    go = 1'b1;
    @(negedge clk) go = 1'b0;
    repeat (2) begin pulse(); idle(4); end
    chk(ptx_count == 1, "R4", "extra sends after repeat go", ptx_count, 1);
    chk(p_run && c_run, "R4", "run held", {p_run, c_run}, 2'b11);

    // R7: vector in same cycle as epoch
    do_reset(1'b1);
    epoch = 1'b1; drv_valid = 1'b1; drv_data = 32'hC0DE_0007;
    @(negedge clk) begin epoch = 1'b0; drv_valid = 1'b0; end
    idle(5);
    chk(!c_run, "R7", "started at capture epoch", c_run, 0);
    push(1'b1, cyc + 1, 32'hC0DE_0007, "R7");
    pulse();
    idle(2);
    // R9: traffic after start ignored
    send(32'hDEAD_0009);
    idle(2);
    chk(c_sv == 32'hC0DE_0007, "R9", "vector after start", c_sv, 32'hC0DE_0007);
    chk(!c_ovr, "R9", "overrun after start", c_ovr, 0);

    // R8: second vector before start
    do_reset(1'b1);
    send(32'h1111_0008);
    idle(2);
    send(32'h2222_0008);
    idle(2);
    chk(c_ovr, "R8", "overrun flag", c_ovr, 1);
    chk(c_sv == 32'h1111_0008, "R8", "first vector kept", c_sv, 32'h1111_0008);
    chk(!c_run, "R5", "started before epoch", c_run, 0);
    push(1'b1, cyc + 1, 32'h1111_0008, "R6");
    pulse();
    idle(3);
    chk(c_ovr, "R8", "overrun sticky", c_ovr, 1);
    chk(c_run, "R6", "follower running", c_run, 1);

    chk(q.size() == 0, "R6", "missing starts", q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule